// File: doc/BRIEF.md
# Programmable Stage-Select Timer

This block is a digital timer built on a 16-bit binary up-counter. The counter advances on every rising clock edge while it is running. The timer output is one counter bit, picked by two select inputs from four taps: stage 8, 10, 13 or 16. That gives a period of N = 256, 1024, 8192 or 65536 clocks.

In recycle mode the output is a free-running square wave at the clock rate divided by N. In single-transition mode the output changes once, N/2 counts after the counter was last cleared, and then stays latched. A polarity input selects either the true output or its complement.

A level-active master reset clears the counter and holds it at zero. After the global reset deasserts, an auto-reset option issues one synchronous clear cycle and lets counting begin. With auto-reset disabled, the counter stays idle until a master reset pulse has been applied and released.

Top module: `stage_timer`

## Requirements
- R1: While running (armed, master reset low, not in the power-up clear cycle), the counter increments by one on each rising clock edge and wraps modulo 2^16.
- R2: Tap selection is {tsel_a, tsel_b}: 00 selects stage 13 (counter bit 12, N=8192), 01 selects stage 10 (bit 9, N=1024), 10 selects stage 8 (bit 7, N=256), 11 selects stage 16 (bit 15, N=65536).
- R3: With recycle=1 and invert=0, the output is low for the first N/2 counts after a clear, then high for N/2 counts, then low again: a square wave of period N clocks.
- R4: With recycle=0 and invert=0, the output goes high once N/2 counts have passed after a clear. It stays high from then on, even when the counter moves past N.
- R5: The single-transition latch is cleared by a master reset or by setting recycle=1. Once cleared, the output again follows the selected tap.
- R6: With invert=1 the output is the complement of the true output, so it starts high after a clear. With invert=0 it starts low.
- R7: While mreset is high, the counter is cleared and held at zero. Counting resumes on the first edge after mreset returns low.
- R8: With auto_off=0, the first clock edge after rst_n deasserts clears the counter, and counting starts on the following edge.
- R9: With auto_off=1, the counter stays at zero after rst_n deasserts until a master reset pulse has been applied and released.
- R10: A change of tsel_a/tsel_b moves the output to the new tap without resetting the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock, rising edge |
| rst_n | input | 1 | Global power-on reset, active low, asynchronous |
| auto_off | input | 1 | 1 disables the power-up auto clear |
| mreset | input | 1 | Master reset, active high, level sensitive |
| tsel_a | input | 1 | Tap select, upper bit |
| tsel_b | input | 1 | Tap select, lower bit |
| recycle | input | 1 | 1 = square wave, 0 = single transition |
| invert | input | 1 | 1 = complemented output |
| tmr_out | output | 1 | Timer output |

## Verification
The assertions assume that auto_off is held steady around the release of rst_n, and that every control input changes only between clock edges, never at one. The bench drives every input on the falling clock edge. It applies the global reset with auto_off already settled, so that the power-up clear cycle and the armed flag are always observed in a defined state. Master reset pulses last at least one full clock, which matches the assumption that a pulse is seen at a rising edge.

// File: rtl/stage_timer.sv
module stage_timer #(
  parameter int CNT_W   = 16,
  parameter int TAP_00  = 12,
  parameter int TAP_01  = 9,
  parameter int TAP_10  = 7,
  parameter int TAP_11  = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic auto_off,
  input  logic mreset,
  input  logic tsel_a,
  input  logic tsel_b,
  input  logic recycle,
  input  logic invert,
  output logic tmr_out
);

  logic [CNT_W-1:0] cnt;
  logic             pwr_first;
  logic             armed;
  logic             fired;
  logic             tap;
  logic             q_true;
  logic             running;

  assign running = armed && !mreset && !pwr_first;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr_first <= 1'b1;
      armed     <= 1'b0;
    end else begin
      pwr_first <= 1'b0;
      if (mreset || (pwr_first && !auto_off))
        armed <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (!running)
      cnt <= '0;
    else
      cnt <= cnt + 1'b1;
  end

  always_comb begin
    unique case ({tsel_a, tsel_b})
      2'b00:   tap = cnt[TAP_00];
      2'b01:   tap = cnt[TAP_01];
      2'b10:   tap = cnt[TAP_10];
      default: tap = cnt[TAP_11];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      fired <= 1'b0;
    else if (mreset || recycle)
      fired <= 1'b0;
    else if (tap)
      fired <= 1'b1;
  end

  assign q_true  = recycle ? tap : (tap | fired);
  assign tmr_out = q_true ^ invert;

  p_count_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    running |=> cnt == $past(cnt) + 1'b1);

  p_mreset_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mreset |=> cnt == '0);

  p_latch_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fired && !recycle && !mreset) |=> fired);

  p_auto_arm_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_first && !auto_off) |=> armed);

  p_idle_unarmed_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !mreset) |=> cnt == '0);

  p_clear_latch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (recycle || mreset) |=> !fired);

endmodule

// File: tb/test_stage_timer.sv
module test_stage_timer;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;
  // {tsel_a, tsel_b, recycle, invert}
  localparam logic [3:0] VEC [NVEC] = '{
    4'b0010, 4'b0110, 4'b1011, 4'b1110, 4'b1000, 4'b0101
  };

  logic clk = 1'b0;
  logic rst_n, auto_off, mreset, tsel_a, tsel_b, recycle, invert;
  logic tmr_out;
  int   n_run = 0;
  int   n_fail = 0;
  bit   done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stage_timer i_stage_timer (
    .clk(clk), .rst_n(rst_n), .auto_off(auto_off), .mreset(mreset),
    .tsel_a(tsel_a), .tsel_b(tsel_b), .recycle(recycle), .invert(invert),
    .tmr_out(tmr_out)
  );

  function automatic int period_of(input logic a, input logic b);
    case ({a, b})
      2'b00:   return 8192;
      2'b01:   return 1024;
      2'b10:   return 256;
      default: return 65536;
    endcase
  endfunction

  task automatic check(input string req, input logic exp);
    n_run++;
    if (tmr_out !== exp) begin
      n_fail++;
      $display("FAIL %s: tmr_out=%b expected %b at %0t", req, tmr_out, exp, $time);
    end
  endtask

  task automatic adv(input int k);
    repeat (k) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic restart();
    @(negedge clk) mreset = 1'b1;
    @(posedge clk);
    @(negedge clk) mreset = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; auto_off = 1'b0; mreset = 1'b0;
    tsel_a = 1'b1; tsel_b = 1'b0; recycle = 1'b1; invert = 1'b0;
    adv(3);
    check("R6 reset level low", 1'b0);
    rst_n = 1'b1;
    adv(128);
    check("R8 auto clear then count 127", 1'b0);
    adv(1);
    check("R8 auto clear then count 128", 1'b1);
    invert = 1'b1; #1;
    check("R6 inverted output", 1'b0);

    for (int v = 0; v < NVEC; v++) begin
      int  n;
      logic rec, inv;
      @(negedge clk);
      {tsel_a, tsel_b, recycle, invert} = VEC[v];
      rec = VEC[v][1]; inv = VEC[v][0];
      n = period_of(VEC[v][3], VEC[v][2]);
      restart();
      check("R6 start level", inv);
      adv(n/2 - 1);
      check(rec ? "R3 before half" : "R4 before half", inv);
      adv(1);
      check(rec ? "R3 at half (R2 tap)" : "R4 at half (R2 tap)", ~inv);
      adv(n/2 - 1);
      check(rec ? "R3 before period" : "R4 held", ~inv);
      adv(1);
      check(rec ? "R3 period wrap R1" : "R4 latched past N", rec ? inv : ~inv);
    end

    rst_n = 1'b0; auto_off = 1'b1; invert = 1'b0; recycle = 1'b1;
    tsel_a = 1'b1; tsel_b = 1'b0;
    adv(2);
    rst_n = 1'b1;
    adv(200);
    check("R9 idle without master reset", 1'b0);
    restart();
    adv(128);
    check("R9 counting after pulse", 1'b1);

    mreset = 1'b1;
    adv(1);
    check("R7 cleared by mreset", 1'b0);
    adv(200);
    check("R7 held while mreset", 1'b0);
    mreset = 1'b0;
    adv(128);
    check("R7 resumes after release", 1'b1);

    recycle = 1'b0;
    restart();
    adv(300);
    check("R4 latched at 300", 1'b1);
    recycle = 1'b1;
    adv(1);
    recycle = 1'b0; #1;
    check("R5 latch cleared by recycle", 1'b0);
    adv(100);
    check("R5 latch set again", 1'b1);
    restart();
    check("R5 latch cleared by mreset", 1'b0);

    recycle = 1'b1;
    restart();
    adv(600);
    check("R10 stage 8 at 600", 1'b0);
    tsel_a = 1'b0; tsel_b = 1'b1; #1;
    check("R10 stage 10 without clear", 1'b1);
    adv(1);
    check("R10 stage 10 next clock", 1'b1);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule